// File: doc/BRIEF.md
# Heartbeat Watchdog Reset Generator

This block watches a heartbeat line that the firmware toggles regularly. It also runs a timebase counter on the system clock. Any transition on the heartbeat, rising or falling, restarts the timebase from zero.

If the heartbeat stays at one level, high or low, for the full timeout window, the block drives an active-low processor reset for a fixed number of cycles. With the default timebase clock of 2 MHz, the default window of 2^20 cycles is a little over half a second. The same event clears the timebase and sends a one-cycle strobe that re-arms a calibration-lock guard further down the chip. A host that wants a clean restart, for example before a calibration routine, only has to stop toggling the heartbeat.

The live timebase count is an output. Downstream logic can use it to open time windows measured from the last restart of the timebase.

Top module: `hbeat_watchdog`

## Requirements
- R1: While `por_n` is low and in the first cycle after it is released, `cpu_rst_n` is 1, `cnt_clr` is 0 and `tb_count` is 0.
- R2: When there is no heartbeat transition and no reset pulse, `tb_count` rises by exactly one on every clock edge.
- R3: Any level change on `heartbeat` is seen through `SYNC_STAGES` synchronizer flops plus one edge flop. With the default of 2 stages, `tb_count` reads 0 after the third clock edge that follows the change. This holds for a rising change, a falling change and a pulse one cycle wide.
- R4: When `heartbeat` stays at one level, low or high, `tb_count` reaches 2^`TIMEOUT_LOG2` − 1. On the next edge `cpu_rst_n` goes low and `tb_count` becomes 0. While the heartbeat keeps toggling often enough, `cpu_rst_n` stays 1.
- R5: Once `cpu_rst_n` goes low, it stays low for exactly `PULSE_LEN` cycles and then returns to 1. A heartbeat transition during the pulse does not lengthen or shorten it.
- R6: During the reset pulse, `tb_count` is held at 0. It counts up from 0 again on the first edge after the pulse ends. A heartbeat transition during the pulse leaves no pending restart behind.
- R7: `cnt_clr` is 1 in the first cycle of each reset pulse only, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (2 MHz in the target system) |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| heartbeat | input | 1 | Firmware heartbeat; any transition is a kick |
| cpu_rst_n | output | 1 | Active-low processor reset pulse |
| cnt_clr | output | 1 | One-cycle strobe at pulse start; re-arms the lock guard |
| tb_count | output | TIMEOUT_LOG2 | Live timebase count since the last restart |

## Verification
Each result has a fixed delay after its stimulus. A heartbeat change driven on a falling edge shows as a zero count after the third rising edge. The reset goes low on the edge after the count shows its maximum value, and it rises again `PULSE_LEN` edges later. The strobe lines up with the first low cycle of the reset. The driver queues every expected value with the absolute cycle in which it is due, counted from the release of power-on reset. The monitor samples the outputs on falling clock edges and compares them only when the queued cycle matches. Because of this, an output that is one cycle early or one cycle late is reported. The bench shortens the window to 2^6 cycles and the pulse to 4 cycles so that it can cover several timeouts.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
   localparam int unsigned DEF_TIMEOUT_LOG2 = 20;
   localparam int unsigned DEF_PULSE_LEN    = 16;
   localparam int unsigned DEF_SYNC_STAGES  = 2;

   typedef enum logic {
      WD_RUN  = 1'b0,
      WD_FIRE = 1'b1
   } wd_phase_e;

   function automatic int unsigned len_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/wdg_kick_detect.sv
`timescale 1ns/1ps
module wdg_kick_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic hb_async,
   output logic kick
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wdg_kick_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], hb_async};
         prev_q  <= chain_q[LAST];
      end
   end

   assign kick = chain_q[LAST] ^ prev_q;

   // R3
   kick_single_chk: assert property (@(posedge clk) disable iff (!por_n)
      kick |=> (prev_q == $past(chain_q[LAST])));
endmodule

// File: rtl/wdg_timebase.sv
`timescale 1ns/1ps
module wdg_timebase #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             kick,
   input  logic             hold,
   output logic             expire,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 4 || CNT_W > 31) begin : g_bad_width
         $error("wdg_timebase: CNT_W out of range 4..31");
      end
   endgenerate

   assign expire = !hold && !kick && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
      end else if (hold || kick || expire) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count = cnt_q;

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!hold && !kick && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
   // R3
   kick_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
      (kick && !hold) |=> (cnt_q == '0));
   // R6
   hold_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      hold |=> (cnt_q == '0));
endmodule

// File: rtl/wdg_pulse.sv
`timescale 1ns/1ps
module wdg_pulse
   import wdg_pkg::*;
#(
   parameter int unsigned PULSE_LEN = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic fire,
   output logic active,
   output logic clr_strobe
);
   localparam int unsigned PW = len_width(PULSE_LEN);
   localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN - 1);

   wd_phase_e     phase_q;
   logic [PW-1:0] left_q;
   logic          clr_q;

   generate
      if (PULSE_LEN < 1) begin : g_bad_len
         $error("wdg_pulse: PULSE_LEN must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         phase_q <= WD_RUN;
         left_q  <= '0;
         clr_q   <= 1'b0;
      end else begin
         clr_q <= 1'b0;
         unique case (phase_q)
            WD_RUN: begin
               if (fire) begin
                  phase_q <= WD_FIRE;
                  left_q  <= LOAD;
                  clr_q   <= 1'b1;
               end
            end
            WD_FIRE: begin
               if (left_q == '0) begin
                  phase_q <= WD_RUN;
               end else begin
                  left_q <= left_q - 1'b1;
               end
            end
            default: phase_q <= WD_RUN;
         endcase
      end
   end

   assign active     = (phase_q == WD_FIRE);
   assign clr_strobe = clr_q;

   // R4
   fire_start_chk: assert property (@(posedge clk) disable iff (!por_n)
      fire |=> active);
   // R5
   no_retrigger_chk: assert property (@(posedge clk) disable iff (!por_n)
      active |-> !fire);
   // R7
   clr_first_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(active) |-> clr_strobe);
   // R7
   clr_only_start_chk: assert property (@(posedge clk) disable iff (!por_n)
      clr_strobe |=> !clr_strobe);
endmodule

// File: rtl/hbeat_watchdog.sv
`timescale 1ns/1ps
module hbeat_watchdog
   import wdg_pkg::*;
#(
   parameter int unsigned TIMEOUT_LOG2 = DEF_TIMEOUT_LOG2,
   parameter int unsigned PULSE_LEN    = DEF_PULSE_LEN,
   parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES
) (
   input  logic                    clk,
   input  logic                    por_n,
   input  logic                    heartbeat,
   output logic                    cpu_rst_n,
   output logic                    cnt_clr,
   output logic [TIMEOUT_LOG2-1:0] tb_count
);
   logic kick;
   logic expire;
   logic pulsing;

   wdg_kick_detect #(.SYNC_STAGES(SYNC_STAGES)) u_kick (
      .clk      (clk),
      .por_n    (por_n),
      .hb_async (heartbeat),
      .kick     (kick)
   );

   wdg_timebase #(.CNT_W(TIMEOUT_LOG2)) u_tb (
      .clk    (clk),
      .por_n  (por_n),
      .kick   (kick),
      .hold   (pulsing),
      .expire (expire),
      .count  (tb_count)
   );

   wdg_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk        (clk),
      .por_n      (por_n),
      .fire       (expire),
      .active     (pulsing),
      .clr_strobe (cnt_clr)
   );

   assign cpu_rst_n = !pulsing;

   // R1
   por_quiet_chk: assert property (@(posedge clk)
      !por_n |-> (cpu_rst_n && !cnt_clr && tb_count == '0));
   // R6
   reset_clears_count_chk: assert property (@(posedge clk) disable iff (!por_n)
      !cpu_rst_n |-> (tb_count == '0));
endmodule

// File: tb/sim_hbeat_watchdog.sv
`timescale 1ns/1ps
module sim_hbeat_watchdog;
   localparam int unsigned LOG2 = 6;
   localparam int unsigned PLEN = 4;
   localparam int K_RST = 0;
   localparam int K_CNT = 1;
   localparam int K_CLR = 2;

   typedef struct {
      int    at;
      int    kind;
      int    val;
      string req;
   } sb_item_t;

   logic            clk = 1'b0;
   logic            por_n = 1'b0;
   logic            hb = 1'b0;
   logic            rst_n;
   logic            clr;
   logic [LOG2-1:0] cnt;

   int       cyc = 0;
   int       checks = 0;
   int       errors = 0;
   bit       done = 1'b0;
   sb_item_t sb[$];

   hbeat_watchdog #(.TIMEOUT_LOG2(LOG2), .PULSE_LEN(PLEN), .SYNC_STAGES(2)) u0 (
      .clk       (clk),
      .por_n     (por_n),
      .heartbeat (hb),
      .cpu_rst_n (rst_n),
      .cnt_clr   (clr),
      .tb_count  (cnt)
   );

   always #4 clk = ~clk;

   always @(posedge clk) if (por_n) cyc <= cyc + 1;

   task automatic expect_at(input int at, input int kind, input int val, input string req);
      sb_item_t it;
      it.at = at; it.kind = kind; it.val = val; it.req = req;
      sb.push_back(it);
   endtask

   task automatic wait_cyc(input int n);
      while (cyc != n) @(negedge clk);
   endtask

   // Monitor: pops due items and compares on falling edges.
   always @(negedge clk) begin
      if (por_n && !done) begin
         while (sb.size() > 0 && sb[0].at == cyc) begin
            sb_item_t it;
            int       act;
            it = sb.pop_front();
            case (it.kind)
               K_RST:   act = int'(rst_n);
               K_CLR:   act = int'(clr);
               default: act = int'(cnt);
            endcase
            checks++;
            if (act != it.val) begin
               errors++;
               $display("FAIL %s cycle %0d kind %0d: actual %0d expected %0d",
                        it.req, cyc, it.kind, act, it.val);
            end
         end
      end
   end

   initial begin
      // R1 reset state
      expect_at(0, K_RST, 1, "R1"); expect_at(0, K_CNT, 0, "R1"); expect_at(0, K_CLR, 0, "R1");
      // R2 free counting
      expect_at(10, K_CNT, 10, "R2");
      // R4 stuck low from reset
      expect_at(63, K_CNT, 63, "R4"); expect_at(63, K_RST, 1, "R4");
      expect_at(64, K_RST, 0, "R4"); expect_at(64, K_CLR, 1, "R7"); expect_at(64, K_CNT, 0, "R6");
      expect_at(65, K_CLR, 0, "R7"); expect_at(65, K_RST, 0, "R5");
      expect_at(67, K_RST, 0, "R5");
      expect_at(68, K_RST, 1, "R5"); expect_at(68, K_CNT, 0, "R6");
      expect_at(70, K_CNT, 2, "R6");
      // R3 rising and falling kicks
      expect_at(102, K_CNT, 34, "R3"); expect_at(103, K_CNT, 0, "R3");
      expect_at(122, K_CNT, 19, "R3"); expect_at(123, K_CNT, 0, "R3");
      expect_at(143, K_CNT, 0, "R3");
      expect_at(180, K_RST, 1, "R4"); expect_at(180, K_CNT, 37, "R2");
      // R4 stuck high
      expect_at(206, K_CNT, 63, "R4"); expect_at(206, K_RST, 1, "R4");
      expect_at(207, K_RST, 0, "R4"); expect_at(207, K_CLR, 1, "R7");
      // R5/R6 kick during pulse ignored
      expect_at(210, K_RST, 0, "R5");
      expect_at(211, K_RST, 1, "R5"); expect_at(211, K_CNT, 0, "R6");
      expect_at(215, K_CNT, 4, "R6");
      expect_at(232, K_CNT, 21, "R2"); expect_at(233, K_CNT, 0, "R3");
      expect_at(253, K_CNT, 0, "R3");
      // R4 stuck low after kicks
      expect_at(316, K_CNT, 63, "R4"); expect_at(316, K_RST, 1, "R4");
      expect_at(317, K_RST, 0, "R4"); expect_at(317, K_CLR, 1, "R7");
      expect_at(318, K_CLR, 0, "R7");
      expect_at(320, K_RST, 0, "R5");
      expect_at(321, K_RST, 1, "R5"); expect_at(321, K_CNT, 0, "R6");
      // R3 one-cycle glitch
      expect_at(342, K_CNT, 21, "R3"); expect_at(343, K_CNT, 0, "R3");
      expect_at(344, K_CNT, 0, "R3"); expect_at(345, K_CNT, 1, "R3");

      repeat (3) @(posedge clk);
      #2 por_n = 1'b1;
      wait_cyc(100); hb = 1'b1;
      wait_cyc(120); hb = 1'b0;
      wait_cyc(140); hb = 1'b1;
      wait_cyc(208); hb = 1'b0;
      wait_cyc(230); hb = 1'b1;
      wait_cyc(250); hb = 1'b0;
      wait_cyc(340); hb = 1'b1;
      wait_cyc(341); hb = 1'b0;
      wait_cyc(352);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R1 scoreboard: actual %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R2 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule